// File: doc/BRIEF.md
# Soft-Start and Overcurrent Latch-Off Sequencer

This block sequences a multiphase buck controller through power-up and overcurrent protection. The voltage on the external timing capacitor is modelled as an unsigned level counter. When the controller is disabled the level is cleared. During start-up it ramps upward and serves as the soft-start reference. Once the output is good, the level is pinned at full scale. While the current limit is active, the level discharges. If it falls below a latch threshold, the controller shuts its PWM outputs off and stays off.

An overcurrent event that clears before the threshold is reached leads to one of two recoveries. If the output is still inside its good window, the controller resumes regulation. Otherwise it starts a fresh soft-start. A latched shutdown clears only when the enable drops or the supply falls under its lockout level. A configuration input turns the latch-off timer off, so that current limiting never ends in shutdown. While the output is still near ground during start-up, the block also asks for the secondary current limit.

Top module: `ss_latchoff_ctrl`

## Requirements
- R1: When `en_i` or `uvlo_ok_i` is low at a clock edge, then after that edge `ss_ref_o` is 0 and `pwm_en_o` and `drv_en_o` are 0, whatever the earlier state, a latched shutdown included.
- R2: With both `en_i` and `uvlo_ok_i` high, the first edge after the disabled state enters start-up with `ss_ref_o` at 0. On each later start-up edge without power-good, `ss_ref_o` rises by RAMP_STEP (default 4) and saturates at full scale (default 255). `pwm_en_o` and `drv_en_o` are 1 during start-up.
- R3: On a start-up edge with `pgood_i` high, the ramp stops, `ss_ref_o` becomes full scale and the block regulates.
- R4: While regulating with `latch_dis_i` low, an edge with `ilim_i` high starts the latch-off delay. On each later edge with `ilim_i` still high, `ss_ref_o` falls by DECAY_STEP (default 2), floored at 0.
- R5: `pwm_en_o` stays 1 for as long as the latch-off delay runs.
- R6: When the decayed value drops below LATCH_TH (default 153), the block latches off. It drives `pwm_en_o` to 0 and keeps `drv_en_o` at 1, and `ss_ref_o` keeps discharging to 0.
- R7: If `ilim_i` is low on a delay edge, the block returns to regulation at full scale when `pgood_i` is high. Otherwise it clears `ss_ref_o` to 0 and starts a new ramp.
- R8: Once latched, `ilim_i` and `pgood_i` have no effect. Only the R1 disable path clears the latch, after which a new start-up follows.
- R9: `sec_lim_o` is high exactly when the block is in start-up and `out_low_i` is high, combinationally.
- R10: While `latch_dis_i` is high, `ilim_i` never starts a latch-off delay. Raising `latch_dis_i` during a running delay returns the block to regulation at full scale.
- R11: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable |
| uvlo_ok_i | input | 1 | Supply above undervoltage lockout |
| pgood_i | input | 1 | Output inside the power-good window |
| ilim_i | input | 1 | Current limit reached |
| out_low_i | input | 1 | Output below 200 mV |
| latch_dis_i | input | 1 | Disables the latch-off timer |
| pwm_en_o | output | 1 | PWM outputs allowed to switch |
| drv_en_o | output | 1 | External driver enable |
| sec_lim_o | output | 1 | Select secondary current limit |
| ss_ref_o | output | DLY_W | Timing-node level / soft-start reference |

## Verification
The bench targets the fork in recovery. An overcurrent that clears with power-good present must restore full scale. Without power-good it must restart from zero, and a design that mixes up the two would either skip soft-start into a shorted output or needlessly ramp down a healthy rail. The bench runs the discharge all the way to the threshold crossing: a design that compared the wrong value or the wrong edge would latch one cycle early or late, and the scoreboard catches the shifted `pwm_en_o` fall. It also applies power-good and clears the overcurrent while latched, to expose a latch that leaks. It toggles the latch-disable input in the middle of a delay, where a broken design would keep discharging.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RAMP  = 3'd1,
    ST_RUN   = 3'd2,
    ST_DECAY = 3'd3,
    ST_LATCH = 3'd4
  } seq_state_e;

  typedef enum logic [2:0] {
    NODE_HOLD  = 3'd0,
    NODE_CLEAR = 3'd1,
    NODE_FULL  = 3'd2,
    NODE_UP    = 3'd3,
    NODE_DOWN  = 3'd4
  } node_cmd_e;

  // Saturating charge step toward a ceiling.
  function automatic int unsigned lvl_charge(int unsigned lvl, int unsigned step,
                                             int unsigned ceil_v);
    if (lvl + step > ceil_v) return ceil_v;
    return lvl + step;
  endfunction

  // Saturating discharge step toward zero.
  function automatic int unsigned lvl_discharge(int unsigned lvl, int unsigned step);
    if (lvl < step) return 0;
    return lvl - step;
  endfunction

endpackage

// File: rtl/ss_dly_node.sv
module ss_dly_node
  import ss_seq_pkg::*;
#(
  parameter int unsigned DLY_W      = 8,
  parameter int unsigned LATCH_TH   = 153,
  parameter int unsigned RAMP_STEP  = 4,
  parameter int unsigned DECAY_STEP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  node_cmd_e        cmd_i,
  output logic [DLY_W-1:0] lvl_o,
  output logic             dn_below_o
);

  localparam int unsigned LVL_TOP = (1 << DLY_W) - 1;

  logic [DLY_W-1:0] lvl_q, lvl_d;
  int unsigned      lvl_dn;

  assign lvl_dn = lvl_discharge(32'(lvl_q), DECAY_STEP);

  always_comb begin
    unique case (cmd_i)
      NODE_CLEAR: lvl_d = '0;
      NODE_FULL:  lvl_d = DLY_W'(LVL_TOP);
      NODE_UP:    lvl_d = DLY_W'(lvl_charge(32'(lvl_q), RAMP_STEP, LVL_TOP));
      NODE_DOWN:  lvl_d = DLY_W'(lvl_dn);
      default:    lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o      = lvl_q;
  assign dn_below_o = (lvl_dn < LATCH_TH);

  // R2: charging never lowers the level
  p_ramp_mono_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == NODE_UP |=> lvl_q >= $past(lvl_q));
  // R4: discharging never raises the level
  p_decay_mono_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == NODE_DOWN |=> lvl_q <= $past(lvl_q));
  // R1: a clear empties the node
  p_clear_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == NODE_CLEAR |=> lvl_q == '0);

endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
  import ss_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       pgood_i,
  input  logic       ilim_i,
  input  logic       latch_dis_i,
  input  logic       dn_below_i,
  output seq_state_e state_o,
  output node_cmd_e  cmd_o
);

  seq_state_e st_q, st_d;
  node_cmd_e  cmd;

  always_comb begin
    st_d = st_q;
    cmd  = NODE_HOLD;
    if (!active_i) begin
      st_d = ST_OFF;
      cmd  = NODE_CLEAR;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_d = ST_RAMP;
          cmd  = NODE_CLEAR;
        end
        ST_RAMP: begin
          if (pgood_i) begin
            st_d = ST_RUN;
            cmd  = NODE_FULL;
          end else begin
            cmd = NODE_UP;
          end
        end
        ST_RUN: begin
          cmd = NODE_FULL;
          if (ilim_i && !latch_dis_i) st_d = ST_DECAY;
        end
        ST_DECAY: begin
          if (latch_dis_i) begin
            st_d = ST_RUN;
            cmd  = NODE_FULL;
          end else if (!ilim_i) begin
            if (pgood_i) begin
              st_d = ST_RUN;
              cmd  = NODE_FULL;
            end else begin
              st_d = ST_RAMP;
              cmd  = NODE_CLEAR;
            end
          end else begin
            cmd = NODE_DOWN;
            if (dn_below_i) st_d = ST_LATCH;
          end
        end
        ST_LATCH: cmd = NODE_DOWN;
        default: begin
          st_d = ST_OFF;
          cmd  = NODE_CLEAR;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign cmd_o   = cmd;

  // R8: a latch survives every input except the disable path
  p_latch_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LATCH && active_i) |=> st_q == ST_LATCH);
  // R10: with latch-off disabled no delay is ever running
  p_no_delay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_dis_i && active_i) |=> st_q != ST_DECAY);
  // R7: a cleared overcurrent leads to regulation or a new ramp
  p_recover_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DECAY && active_i && !ilim_i && !latch_dis_i)
      |=> (st_q == ST_RUN || st_q == ST_RAMP));

endmodule

// File: rtl/ss_latchoff_ctrl.sv
module ss_latchoff_ctrl
  import ss_seq_pkg::*;
#(
  parameter int unsigned DLY_W      = 8,
  parameter int unsigned LATCH_TH   = 153,
  parameter int unsigned RAMP_STEP  = 4,
  parameter int unsigned DECAY_STEP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             uvlo_ok_i,
  input  logic             pgood_i,
  input  logic             ilim_i,
  input  logic             out_low_i,
  input  logic             latch_dis_i,
  output logic             pwm_en_o,
  output logic             drv_en_o,
  output logic             sec_lim_o,
  output logic [DLY_W-1:0] ss_ref_o
);

  localparam logic [DLY_W-1:0] REF_FULL = {DLY_W{1'b1}};

  logic       active;
  logic       dn_below;
  seq_state_e state;
  node_cmd_e  cmd;
  logic [DLY_W-1:0] lvl;

  assign active = en_i & uvlo_ok_i;

  ss_seq_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .pgood_i     (pgood_i),
    .ilim_i      (ilim_i),
    .latch_dis_i (latch_dis_i),
    .dn_below_i  (dn_below),
    .state_o     (state),
    .cmd_o       (cmd)
  );

  ss_dly_node #(
    .DLY_W      (DLY_W),
    .LATCH_TH   (LATCH_TH),
    .RAMP_STEP  (RAMP_STEP),
    .DECAY_STEP (DECAY_STEP)
  ) i_node (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .lvl_o      (lvl),
    .dn_below_o (dn_below)
  );

  assign pwm_en_o  = (state == ST_RAMP) || (state == ST_RUN) || (state == ST_DECAY);
  assign drv_en_o  = (state != ST_OFF);
  assign sec_lim_o = (state == ST_RAMP) && out_low_i;
  assign ss_ref_o  = lvl;

  // R1: disable clears everything on the next edge
  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (!pwm_en_o && !drv_en_o && ss_ref_o == '0));
  // R3: power-good during start-up pins the reference at full scale
  p_pgood_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RAMP && active && pgood_i) |=> (ss_ref_o == REF_FULL && pwm_en_o));
  // R9: secondary limit only while switching with a low output
  p_seclim_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_lim_o |-> (pwm_en_o && out_low_i));
  // R6: a shut-down controller keeps its drivers enabled and never rises
  p_latch_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o && !pwm_en_o && active) |=> (!pwm_en_o && ss_ref_o <= $past(ss_ref_o)));

endmodule

// File: tb/test_ss_latchoff_ctrl.sv
module test_ss_latchoff_ctrl;

  localparam int W    = 8;
  localparam int FULL = 255;
  localparam int TH   = 153;
  localparam int UP   = 4;
  localparam int DN   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, uv = 0, pg = 0, ilim = 0, olow = 0, dis = 0;
  logic pwm, drv, sec;
  logic [W-1:0] sref;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R11";
  bit done = 0;

  always #5 clk = ~clk;

  ss_latchoff_ctrl i_ss_latchoff_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .uvlo_ok_i(uv), .pgood_i(pg),
    .ilim_i(ilim), .out_low_i(olow), .latch_dis_i(dis),
    .pwm_en_o(pwm), .drv_en_o(drv), .sec_lim_o(sec), .ss_ref_o(sref)
  );

  typedef struct {
    bit    pwm;
    bit    drv;
    bit    starting;
    int    lvl;
    string req;
  } exp_t;

  exp_t q[$];

  // Reference model: modes 0 idle, 1 start-up, 2 regulate, 3 delay, 4 shut down
  int mode = 0;
  int lvl  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0;
      lvl  = 0;
    end else begin
      if (!(en && uv)) begin
        mode = 0; lvl = 0;
      end else if (mode == 0) begin
        mode = 1;
      end else if (mode == 1) begin
        if (pg) begin mode = 2; lvl = FULL; end
        else lvl = (lvl + UP > FULL) ? FULL : lvl + UP;
      end else if (mode == 2) begin
        lvl = FULL;
        if (ilim && !dis) mode = 3;
      end else if (mode == 3) begin
        if (dis || (!ilim && pg)) begin mode = 2; lvl = FULL; end
        else if (!ilim) begin mode = 1; lvl = 0; end
        else begin
          lvl = (lvl < DN) ? 0 : lvl - DN;
          if (lvl < TH) mode = 4;
        end
      end else begin
        lvl = (lvl < DN) ? 0 : lvl - DN;
      end
      q.push_back('{pwm: (mode >= 1 && mode <= 3), drv: (mode != 0),
                    starting: (mode == 1), lvl: lvl, req: cur_req});
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares one expected item per cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.req, "pwm_en", int'(pwm), int'(e.pwm));
      check(e.req, "drv_en", int'(drv), int'(e.drv));
      check(e.req, "ss_ref", int'(sref), e.lvl);
      check("R9", "sec_lim", int'(sec), int'(e.starting && olow));
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    wait_cyc(2);
    // R11: outputs held at zero during reset
    check("R11", "pwm_en in reset", int'(pwm), 0);
    check("R11", "drv_en in reset", int'(drv), 0);
    check("R11", "ss_ref in reset", int'(sref), 0);
    rst_n = 1;
    cur_req = "R1";
    wait_cyc(3);

    // R2 and R9: start-up ramp with the output near ground, then above it
    cur_req = "R2";
    en = 1; uv = 1; olow = 1;
    wait_cyc(10);
    olow = 0;
    wait_cyc(8);
    // R3: power-good pins the reference
    cur_req = "R3";
    pg = 1;
    wait_cyc(4);
    check("R3", "ss_ref after pgood", int'(sref), FULL);

    // R4/R5: short delay, cleared with power-good present -> R7 regulation
    cur_req = "R5";
    ilim = 1;
    wait_cyc(20);
    check("R5", "pwm_en during delay", int'(pwm), 1);
    check("R4", "ss_ref decayed", int'(sref), FULL - 19 * DN);
    cur_req = "R7";
    ilim = 0;
    wait_cyc(3);
    check("R7", "ss_ref restored", int'(sref), FULL);

    // R7: delay cleared without power-good -> new soft-start from zero
    cur_req = "R4";
    ilim = 1;
    wait_cyc(15);
    cur_req = "R7";
    pg = 0; ilim = 0;
    wait_cyc(1);
    check("R7", "ss_ref after restart", int'(sref), 0);
    cur_req = "R2";
    wait_cyc(70);
    check("R2", "ramp saturates", int'(sref), FULL);
    pg = 1;
    wait_cyc(3);

    // R6: sustained overcurrent latches off
    cur_req = "R6";
    ilim = 1;
    wait_cyc(70);
    check("R6", "pwm_en latched", int'(pwm), 0);
    check("R6", "drv_en latched", int'(drv), 1);
    // R8: clearing the overcurrent with power-good has no effect
    cur_req = "R8";
    ilim = 0; pg = 1;
    wait_cyc(12);
    check("R8", "pwm_en still latched", int'(pwm), 0);
    // R1 clears the latch, then a new start-up
    cur_req = "R1";
    en = 0;
    wait_cyc(3);
    check("R1", "drv_en disabled", int'(drv), 0);
    cur_req = "R8";
    pg = 0; en = 1;
    wait_cyc(6);
    check("R8", "pwm_en after re-enable", int'(pwm), 1);
    cur_req = "R3";
    pg = 1;
    wait_cyc(3);

    // R10: latch-off disabled, overcurrent never decays
    cur_req = "R10";
    dis = 1; ilim = 1;
    wait_cyc(30);
    check("R10", "ss_ref held", int'(sref), FULL);
    cur_req = "R4";
    dis = 0;
    wait_cyc(20);
    cur_req = "R10";
    dis = 1;
    wait_cyc(3);
    check("R10", "ss_ref restored", int'(sref), FULL);
    ilim = 0; dis = 0;
    wait_cyc(3);

    // R1: supply lockout while regulating
    cur_req = "R1";
    uv = 0;
    wait_cyc(4);
    check("R1", "ss_ref after lockout", int'(sref), 0);
    wait_cyc(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule